// File: doc/BRIEF.md
# Prioritized Timing Event Encoder

This block gathers timing event requests and, once per transmit slot, picks a single event to hand to a downstream serializer as a framed 12-bit word. Requests come from two places. The first is 64 hardware trigger lines, presented one at a time as an index. The second is a software queue that is filled through a small register port. Hardware input `i` always carries event code `i`. Codes 64 and above belong to the software queue.

A writable table assigns a priority level to every 8-bit event code. Priorities can therefore be changed without touching any code value. A lockout window opens when the pre-pulse event goes out and closes when the extraction event goes out. While it is open, hardware events whose priority is below a programmable threshold are held back, and so is the whole software queue. The lockout keeps those events from delaying extraction. The register port also returns live status and error flags that clear when read.

Top module: `tev_encoder`

## Requirements
- R1: Every output word is laid out as follows: bit 11 is a start bit of 0, bits 10:3 hold the event code, bit 2 is an even-parity bit equal to the XOR of the code, and bits 1:0 are stop bits of `11`.
- R2: `tx_word` changes only in the cycle after `tx_ready` is high. When nothing is eligible on a ready pulse, the word carries the idle code 0x00. The reset value is also the idle word.
- R3: Among eligible hardware requests, the one with the highest table priority is sent. On a tie, the lower input index wins.
- R4: A write to address 3 stores priority `wdata[2:0]` for code `wdata[15:8]`. All priority levels reset to 0.
- R5: A request stays pending until its word is sent, and sending it clears the request. If an input triggers again while its request is pending, the new event is dropped and sticky status bit 6 is set.
- R6: A trigger index above 63 is rejected and sets sticky status bit 5.
- R7: A write to address 1 with a code of 64 or more is queued. Queued codes go out in arrival order, and only on slots where no hardware request is eligible.
- R8: A queue write with a code below 64 is discarded and sets sticky status bit 4.
- R9: Status bit 0 shows that the queue is empty and bit 1 that it is full, both live. A queue write made while the queue is full is dropped and sets sticky status bit 3.
- R10: Sending code 62 opens the lockout and sending code 63 closes it. Status bit 2 reads 1 while the lockout is open. During lockout, hardware codes with a priority below the threshold (address 2, `wdata[2:0]`) and all queued codes are held back.
- R11: A read pulse returns the register on `reg_rdata` in the following cycle (address 0 is status, address 2 is the threshold). A status read clears the sticky bits, except that an error arriving in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | A hardware trigger is presented this cycle |
| trig_idx | input | 7 | Index of the trigger input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the cycle after `reg_rd` |
| tx_ready | input | 1 | Serializer requests the next word |
| tx_word | output | 12 | Framed event word |

## Verification
The bench keeps the default of 64 inputs and 8-bit codes, so ties and index ordering are exercised across the full trigger range. It builds the block with a queue depth of 4, which makes both the full flag and the dropped-write flag reachable after only a handful of register writes. The pre-pulse and extraction codes stay at 62 and 63. The randomized traffic draws triggers from inputs 0 to 61 only, so the lockout is left to the directed cases, where the threshold gating and the holding of the queue are checked step by step.

// File: rtl/tev_pkg.sv
package tev_pkg;
   localparam int CODE_W = 8;
   localparam int WORD_W = CODE_W + 4;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [WORD_W-1:0] word_t;

   // start bit 0, code, even parity, two stop bits of 1
   function automatic word_t frame_code(input code_t c);
      return {1'b0, c, ^c, 2'b11};
   endfunction
endpackage

// File: rtl/tev_fifo.sv
module tev_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [AW-1:0] LAST     = AW'(DEPTH-1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   assign head  = mem[rd_ptr];
   assign full  = (count == FULL_CNT);
   assign empty = (count == '0);
endmodule

// File: rtl/tev_prio_table.sv
module tev_prio_table #(
   parameter int CODE_W = 8,
   parameter int PRIO_W = 3,
   parameter int N_OUT  = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [CODE_W-1:0]        waddr,
   input  logic [PRIO_W-1:0]        wdata,
   output logic [N_OUT*PRIO_W-1:0]  prio_flat
);
   localparam int ENTRIES = 2**CODE_W;

   logic [PRIO_W-1:0] tbl [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
      end else if (we) begin
         tbl[waddr] <= wdata;
      end
   end

   for (genvar g = 0; g < N_OUT; g++) begin : g_rd
      assign prio_flat[g*PRIO_W +: PRIO_W] = tbl[g];
   end
endmodule

// File: rtl/tev_arbiter.sv
module tev_arbiter #(
   parameter int N_IN   = 64,
   parameter int PRIO_W = 3,
   localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic [N_IN-1:0]         pend,
   input  logic [N_IN*PRIO_W-1:0]  prio_flat,
   input  logic                    lockout,
   input  logic [PRIO_W-1:0]       thr,
   output logic                    hit,
   output logic [SEL_W-1:0]        sel
);
   logic [PRIO_W-1:0] best;
   logic [PRIO_W-1:0] p;

   // scan from the top index down; ">=" lets the lower index take ties
   always_comb begin
      hit  = 1'b0;
      sel  = '0;
      best = '0;
      p    = '0;
      for (int i = N_IN-1; i >= 0; i--) begin
         p = prio_flat[i*PRIO_W +: PRIO_W];
         if (pend[i] && (!lockout || p >= thr) && (!hit || p >= best)) begin
            hit  = 1'b1;
            sel  = SEL_W'(i);
            best = p;
         end
      end
   end
endmodule

// File: rtl/tev_encoder.sv
module tev_encoder
   import tev_pkg::*;
#(
   parameter int N_IN       = 64,
   parameter int PRIO_W     = 3,
   parameter int FIFO_DEPTH = 8,
   parameter int PP_CODE    = 62,
   parameter int EXT_CODE   = 63,
   parameter int DATA_W     = 16,
   localparam int SEL_W     = $clog2(N_IN),
   localparam int IDX_W     = SEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_valid,
   input  logic [IDX_W-1:0]  trig_idx,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tx_ready,
   output logic [WORD_W-1:0] tx_word
);
   localparam logic [1:0] A_STATUS = 2'd0;
   localparam logic [1:0] A_QUEUE  = 2'd1;
   localparam logic [1:0] A_THRESH = 2'd2;
   localparam logic [1:0] A_PRIO   = 2'd3;

   if (N_IN < 2 || N_IN >= 2**CODE_W) begin : g_bad_nin
      $error("N_IN must lie between 2 and the code space");
   end
   if (PP_CODE >= N_IN || EXT_CODE >= N_IN || PP_CODE == EXT_CODE) begin : g_bad_mark
      $error("marker codes must be distinct hardware codes");
   end
   if (DATA_W < 8 + CODE_W || PRIO_W > 8) begin : g_bad_data
      $error("DATA_W too narrow for the table write field");
   end

   logic [N_IN-1:0]        pend;
   logic [N_IN*PRIO_W-1:0] prio_flat;
   logic                   hw_hit;
   logic [SEL_W-1:0]       hw_sel;
   logic                   lockout;
   logic [PRIO_W-1:0]      thr;
   logic                   s_lost, s_range, s_qlow, s_qfull;
   logic                   q_full, q_empty;
   code_t                  q_head;

   // trigger intake
   logic             trig_ok, trig_bad, trig_dup;
   logic [SEL_W-1:0] trig_bit;
   assign trig_bit = trig_idx[SEL_W-1:0];
   assign trig_ok  = trig_valid && (trig_idx < IDX_W'(N_IN));
   assign trig_bad = trig_valid && !trig_ok;
   assign trig_dup = trig_ok && pend[trig_bit];

   // register port decode
   logic  q_wr, q_low, q_push, q_over, tbl_we, status_rd;
   code_t q_code;
   assign q_wr      = reg_wr && reg_addr == A_QUEUE;
   assign q_code    = reg_wdata[CODE_W-1:0];
   assign q_low     = q_wr && (q_code < CODE_W'(N_IN));
   assign q_push    = q_wr && !q_low;
   assign q_over    = q_push && q_full;
   assign tbl_we    = reg_wr && reg_addr == A_PRIO;
   assign status_rd = reg_rd && reg_addr == A_STATUS;

   // slot decision
   logic  send_hw, sw_go;
   code_t sent_code;
   assign send_hw   = tx_ready && hw_hit;
   assign sw_go     = tx_ready && !hw_hit && !lockout && !q_empty;
   assign sent_code = send_hw ? CODE_W'(hw_sel) : (sw_go ? q_head : '0);

   tev_prio_table #(.CODE_W(CODE_W), .PRIO_W(PRIO_W), .N_OUT(N_IN)) i_table (
      .clk(clk), .rst_n(rst_n), .we(tbl_we),
      .waddr(reg_wdata[8 +: CODE_W]), .wdata(reg_wdata[PRIO_W-1:0]),
      .prio_flat(prio_flat)
   );

   tev_arbiter #(.N_IN(N_IN), .PRIO_W(PRIO_W)) i_arb (
      .pend(pend), .prio_flat(prio_flat), .lockout(lockout), .thr(thr),
      .hit(hw_hit), .sel(hw_sel)
   );

   tev_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) i_queue (
      .clk(clk), .rst_n(rst_n), .push(q_push), .pop(sw_go), .din(q_code),
      .head(q_head), .full(q_full), .empty(q_empty)
   );

   logic [N_IN-1:0] set_mask, clr_mask;
   assign set_mask = (trig_ok && !trig_dup) ? (N_IN'(1) << trig_bit) : '0;
   assign clr_mask = send_hw ? (N_IN'(1) << hw_sel) : '0;

   logic [DATA_W-1:0] status;
   assign status = DATA_W'({s_lost, s_range, s_qlow, s_qfull, lockout, q_full, q_empty});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= '0;
         tx_word   <= frame_code('0);
         lockout   <= 1'b0;
         thr       <= '0;
         s_lost    <= 1'b0;
         s_range   <= 1'b0;
         s_qlow    <= 1'b0;
         s_qfull   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         pend <= (pend & ~clr_mask) | set_mask;
         if (tx_ready) tx_word <= frame_code(sent_code);
         if (send_hw && hw_sel == SEL_W'(PP_CODE))  lockout <= 1'b1;
         if (send_hw && hw_sel == SEL_W'(EXT_CODE)) lockout <= 1'b0;
         if (reg_wr && reg_addr == A_THRESH) thr <= reg_wdata[PRIO_W-1:0];
         s_lost  <= trig_dup || (s_lost  && !status_rd);
         s_range <= trig_bad || (s_range && !status_rd);
         s_qlow  <= q_low    || (s_qlow  && !status_rd);
         s_qfull <= q_over   || (s_qfull && !status_rd);
         if (reg_rd) begin
            case (reg_addr)
               A_STATUS: reg_rdata <= status;
               A_THRESH: reg_rdata <= DATA_W'(thr);
               default:  reg_rdata <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/tev_encoder_chk.sv
module tev_encoder_chk #(
   parameter int N_IN   = 64,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 6,
   parameter int IDX_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_ready,
   input logic [11:0]       tx_word,
   input logic              trig_valid,
   input logic [IDX_W-1:0]  trig_idx,
   input logic [N_IN-1:0]   pend,
   input logic              s_lost,
   input logic              s_range,
   input logic              s_qlow,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              lockout,
   input logic              q_full,
   input logic              q_empty
);
   a_r1_frame: assert property (@(posedge clk) disable iff (!rst_n)
      tx_word[11] == 1'b0 && tx_word[1:0] == 2'b11 && ^tx_word[10:2] == 1'b0);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_ready |=> $stable(tx_word));

   a_r5_lost: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid && trig_idx < IDX_W'(N_IN) && pend[trig_idx[SEL_W-1:0]] |=> s_lost);

   a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid && trig_idx >= IDX_W'(N_IN) |=> s_range);

   a_r8_qlow: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == 2'd1 && reg_wdata[7:0] < 8'(N_IN) |=> s_qlow);

   a_r9_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full && q_empty));

   a_r10_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
      lockout && tx_ready |=> tx_word[10:3] < 8'(N_IN));
endmodule

bind tev_encoder tev_encoder_chk #(
   .N_IN(N_IN), .DATA_W(DATA_W), .SEL_W(SEL_W), .IDX_W(IDX_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_word(tx_word),
   .trig_valid(trig_valid), .trig_idx(trig_idx), .pend(pend),
   .s_lost(s_lost), .s_range(s_range), .s_qlow(s_qlow),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .lockout(lockout), .q_full(q_full), .q_empty(q_empty)
);

// File: tb/test_tev_encoder.sv
module test_tev_encoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_valid = 1'b0;
   logic [6:0]  trig_idx = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tx_ready = 1'b0;
   logic [11:0] tx_word;

   int errors = 0;
   int checks = 0;

   int m_prio [64];
   bit m_pend [64];
   int mq[$];

   always #2.5 clk = ~clk;

   tev_encoder #(.FIFO_DEPTH(4)) i_tev_encoder (
      .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_idx(trig_idx),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .tx_ready(tx_ready), .tx_word(tx_word)
   );

   function automatic logic [11:0] fw(input int c);
      logic [7:0] b;
      b = c[7:0];
      return {1'b0, b, ^b, 2'b11};
   endfunction

   // highest priority, lowest index; returns -1 if none eligible
   function automatic int pick(input bit lk, input int th);
      int best, bp;
      best = -1; bp = -1;
      for (int i = 0; i < 64; i++)
         if (m_pend[i] && (!lk || m_prio[i] >= th) && m_prio[i] > bp) begin
            best = i; bp = m_prio[i];
         end
      return best;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wr = 1'b0;
   endtask

   task automatic read_status(output logic [15:0] v);
      reg_rd = 1'b1; reg_addr = 2'd0;
      cyc();
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic trig(input int idx);
      trig_valid = 1'b1; trig_idx = idx[6:0];
      cyc();
      trig_valid = 1'b0;
   endtask

   task automatic send(output logic [11:0] w);
      tx_ready = 1'b1;
      cyc();
      tx_ready = 1'b0;
      w = tx_word;
   endtask

   task automatic set_prio(input int c, input int p);
      reg_write(2'd3, {c[7:0], 5'b0, p[2:0]});
      if (c < 64) m_prio[c] = p;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [11:0] w;
      logic [15:0] s;
      bit m_lost, m_over;
      for (int i = 0; i < 64; i++) begin m_prio[i] = 0; m_pend[i] = 0; end
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // reset state
      chk("R2 reset idle word", 16'(tx_word), 16'(fw(0)));
      read_status(s);
      chk("R9 reset status empty", s, 16'h0001);

      // R3 tie: lower index wins, pending cleared on send
      trig(9); trig(5);
      send(w); chk("R3 tie lower index", 16'(w), 16'(fw(5)));
      repeat (3) cyc();
      chk("R2 word held without ready", 16'(tx_word), 16'(fw(5)));
      send(w); chk("R3 second", 16'(w), 16'(fw(9)));
      send(w); chk("R2 idle when empty", 16'(w), 16'(fw(0)));

      // R4 table raises code 9 above code 5
      set_prio(9, 5);
      trig(5); trig(9);
      send(w); chk("R4 table priority", 16'(w), 16'(fw(9)));
      send(w); chk("R4 lower after", 16'(w), 16'(fw(5)));

      // R5 retrigger while pending
      trig(7); trig(7);
      read_status(s); chk("R5 lost flag", s, 16'h0041);
      read_status(s); chk("R11 read clears sticky", s, 16'h0001);
      send(w); chk("R5 single event kept", 16'(w), 16'(fw(7)));
      send(w); chk("R5 pending cleared", 16'(w), 16'(fw(0)));

      // R6 out of range index
      trig(70);
      read_status(s); chk("R6 range flag", s, 16'h0021);
      send(w); chk("R6 nothing queued", 16'(w), 16'(fw(0)));

      // R8 low code into queue
      reg_write(2'd1, 16'd10);
      read_status(s); chk("R8 queue low flag, still empty", s, 16'h0011);

      // R7/R9 queue fill, overflow, ordering below hardware
      for (int c = 100; c < 105; c++) reg_write(2'd1, 16'(c));
      trig(3);
      read_status(s); chk("R9 full and overflow flags", s, 16'h000A);
      send(w); chk("R7 hardware first", 16'(w), 16'(fw(3)));
      for (int c = 100; c < 104; c++) begin
         send(w); chk("R7 queue order", 16'(w), 16'(fw(c)));
      end
      send(w); chk("R9 overflow dropped", 16'(w), 16'(fw(0)));

      // R10 lockout window
      reg_write(2'd2, 16'd4);
      reg_rd = 1'b1; reg_addr = 2'd2; cyc(); reg_rd = 1'b0;
      chk("R11 threshold readback", reg_rdata, 16'd4);
      set_prio(62, 7); set_prio(63, 7); set_prio(20, 2); set_prio(30, 5);
      trig(62);
      send(w); chk("R10 pre-pulse sent", 16'(w), 16'(fw(62)));
      read_status(s); chk("R10 lockout flag", s, 16'h0005);
      trig(20); trig(30); reg_write(2'd1, 16'd120);
      send(w); chk("R10 high priority passes", 16'(w), 16'(fw(30)));
      send(w); chk("R10 low and queue held", 16'(w), 16'(fw(0)));
      trig(63);
      send(w); chk("R10 extraction sent", 16'(w), 16'(fw(63)));
      read_status(s); chk("R10 lockout cleared", s, 16'h0000);
      send(w); chk("R10 low released", 16'(w), 16'(fw(20)));
      send(w); chk("R10 queue released", 16'(w), 16'(fw(120)));
      send(w); chk("R10 idle after", 16'(w), 16'(fw(0)));

      // random traffic, lockout codes avoided
      void'($urandom(32'd1234));
      for (int r = 0; r < 40; r++) begin
         int n, nsw;
         m_lost = 0; m_over = 0;
         for (int k = 0; k < 3; k++) set_prio($urandom_range(0, 61), $urandom_range(0, 7));
         n = $urandom_range(1, 6);
         for (int k = 0; k < n; k++) begin
            int idx;
            idx = $urandom_range(0, 61);
            trig(idx);
            if (m_pend[idx]) m_lost = 1; else m_pend[idx] = 1;
         end
         nsw = $urandom_range(0, 5);
         for (int k = 0; k < nsw; k++) begin
            int c;
            c = $urandom_range(64, 255);
            reg_write(2'd1, 16'(c));
            if (mq.size() < 4) mq.push_back(c); else m_over = 1;
         end
         forever begin
            int e;
            e = pick(0, 0);
            if (e >= 0) m_pend[e] = 0;
            else if (mq.size() > 0) e = mq.pop_front();
            send(w);
            chk("R3 random pick", 16'(w), 16'(fw(e < 0 ? 0 : e)));
            if (e < 0) break;
         end
         read_status(s);
         chk("R5 random sticky", s, 16'({m_lost, 2'b00, m_over, 3'b001}));
      end

      finish_run();
   end
endmodule